// File: doc/BRIEF.md
# SPI Device Status Poller

This block repeatedly reads a one-byte status register from an SPI peripheral. It stops when one of three things happens. The first is that a masked condition is met. The second is that an error bit shows up. The third is that a clock-counted time budget runs out. A controller pulses `start` and picks the condition with `mask_ready`. It also supplies a budget in clock cycles. When the poll ends, the block returns a one-cycle `done`, the last status byte and exactly one result flag.

The SPI bus is shared with other agents. The poller raises `bus_req` and drives no SPI activity until `bus_gnt` is seen. It drops `bus_req` in the same cycle that it reports `done`.

Each status sample is made of two one-byte transactions, with chip select released between them. The reply to the first transaction is thrown away, and only the second reply is evaluated. The block also gives a plain `operating` indication for the surrounding logic. This is true once a status has been captured, program mode is off, and the captured status is zero. All pins are plain control and status signals. There is no data stream, so there is no valid/ready back-pressure.

Top module: `spi_status_poller`

## Requirements
- R1: Every transaction uses SPI mode 0 with the serial clock idle low. The poller shifts out the read-status code 0x00 on MOSI MSB first, changes MOSI after a falling clock edge, and samples MISO on the rising clock edge. The captured byte is MSB first.
- R2: Each sample is two separate 8-bit chip-select transactions, with `spi_cs_n` high between them. The first reply is ignored, even if it has error bits set, and only the second reply is evaluated.
- R3: In the evaluated byte, bit 0 means busy, bit 1 means ready, bit 2 means protocol violation and bit 3 means link error. If bit 2 or bit 3 is set, polling ends at once with `res_error`. This check comes before the success and timeout checks.
- R4: `mask_ready`=0 selects mask 0x00 and `mask_ready`=1 selects mask 0x02. The poll ends with `res_ok` when (status AND (0x01 OR mask)) equals mask. Bits 7..4 take no part in this test.
- R5: At `start`, the time budget is loaded from `timeout_cycles`. A value of 0 selects the parameter `DEFAULT_TIMEOUT` instead. The budget counts down once per clock and stops at zero. It is checked only after a complete sample, and only after the error and success checks. If it has run out, the poll ends with `res_timeout`.
- R6: `bus_req` rises in the cycle after an accepted `start`. `spi_cs_n` never goes low unless `bus_req` and `bus_gnt` are both high. `bus_req` is low in the cycle in which `done` is high.
- R7: `done` is high for exactly one cycle per poll, and exactly one of `res_ok`, `res_timeout` and `res_error` is high in that cycle. The flags and `status_q` (the last evaluated byte) hold until the next accepted `start`.
- R8: A `start` pulse that arrives while `active` is high is ignored. The running poll neither restarts nor produces an extra `done`.
- R9: `operating` is high exactly when a status byte has been captured since reset, `program_mode` is low, and `status_q` equals 0x00.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `bus_req`=0, `done`=0, all result flags are 0, `active`=0 and `operating`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a poll (accepted only while idle) |
| mask_ready | input | 1 | 0: mask none, 1: mask ready bit |
| timeout_cycles | input | TMR_W | Time budget in clocks, 0 selects DEFAULT_TIMEOUT |
| program_mode | input | 1 | Program mode indication, used only for `operating` |
| bus_req | output | 1 | SPI bus request |
| bus_gnt | input | 1 | SPI bus grant |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the peripheral |
| spi_miso | input | 1 | SPI data from the peripheral |
| done | output | 1 | One-cycle end-of-poll pulse |
| status_q | output | 8 | Last evaluated status byte |
| res_ok | output | 1 | Poll met its condition |
| res_timeout | output | 1 | Time budget ran out |
| res_error | output | 1 | Error bit seen |
| active | output | 1 | Poll in progress |
| operating | output | 1 | Program mode off and captured status is zero |

## Verification
`done`, the flags and `status_q` are all set at the same clock edge, one cycle after the end of the guard gap that follows the second transaction's chip-select release. The bench therefore waits on `done` at falling clock edges and reads every result in that same sample. On the following falling edge it checks that `done` has dropped while the flags hold. Transaction counts, MOSI contents and grant violations are collected by the bench's SPI peripheral model and compared after each poll. Timeout cases use a budget shorter than one sample, so the expected end point does not depend on counting exact cycles.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_RDY  = 1;
  localparam int BIT_VIOL = 2;
  localparam int BIT_LERR = 3;
  localparam logic [STAT_W-1:0] CMD_RD_STATUS = 8'h00;

  typedef enum logic [2:0] {
    P_IDLE, P_REQ, P_FIRST, P_SECOND
  } poll_st_t;

  typedef enum logic [2:0] {
    X_IDLE, X_SETUP, X_HIGH, X_LOW, X_GAP
  } xfer_st_t;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer
  import poll_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [STAT_W-1:0] tx_byte,
  output logic [STAT_W-1:0] rx_byte,
  output logic              fin,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(STAT_W);
  localparam logic [DIV_W-1:0] DIV_LOAD = DIV_W'(HALF_DIV - 1);

  xfer_st_t          st;
  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  bitn;
  logic [STAT_W-1:0] tx_sh, rx_sh;
  logic              tick;

  assign tick    = (div == '0);
  assign mosi    = tx_sh[STAT_W-1];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= X_IDLE; div <= '0; bitn <= '0;
      tx_sh <= '0; rx_sh <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!tick) div <= div - 1'b1;
      case (st)
        X_IDLE: if (go) begin
          cs_n <= 1'b0; tx_sh <= tx_byte; bitn <= '0;
          div <= DIV_LOAD; st <= X_SETUP;
        end
        X_SETUP, X_LOW: if (tick) begin
          sclk <= 1'b1; rx_sh <= {rx_sh[STAT_W-2:0], miso};
          div <= DIV_LOAD; st <= X_HIGH;
        end
        X_HIGH: if (tick) begin
          sclk <= 1'b0; div <= DIV_LOAD;
          if (bitn == BIT_W'(STAT_W-1)) begin
            cs_n <= 1'b1; st <= X_GAP;
          end else begin
            bitn <= bitn + 1'b1;
            tx_sh <= {tx_sh[STAT_W-2:0], 1'b0};
            st <= X_LOW;
          end
        end
        X_GAP: if (tick) begin
          fin <= 1'b1; st <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // R1: serial clock may only toggle high inside a selected transaction
  assert_sclk_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R2: chip select is released for the whole gap before completion
  assert_cs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> cs_n);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TMR_W = 32,
  parameter logic [TMR_W-1:0] DEFAULT_TIMEOUT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] budget,
  input  logic             run,
  output logic             expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= (budget == '0) ? DEFAULT_TIMEOUT : budget;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5: once the budget is used up it stays used up until reloaded
  assert_expiry_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/status_eval.sv
module status_eval
  import poll_pkg::*;
(
  input  logic [STAT_W-1:0] stat,
  input  logic              want_ready,
  output logic              is_err,
  output logic              is_met
);
  logic [STAT_W-1:0] mask, sel;

  always_comb begin
    mask = '0;
    mask[BIT_RDY] = want_ready;
    sel  = mask;
    sel[BIT_BUSY] = 1'b1;
    is_err = stat[BIT_VIOL] | stat[BIT_LERR];
    is_met = ((stat & sel) == mask);
  end
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller
  import poll_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int TMR_W = 32,
  parameter logic [TMR_W-1:0] DEFAULT_TIMEOUT = TMR_W'(200_000_000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mask_ready,
  input  logic [TMR_W-1:0]  timeout_cycles,
  input  logic              program_mode,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              done,
  output logic [STAT_W-1:0] status_q,
  output logic              res_ok,
  output logic              res_timeout,
  output logic              res_error,
  output logic              active,
  output logic              operating
);
  poll_st_t          st;
  logic              go, fin, want_rdy, seen;
  logic              expired, is_err, is_met, accept;
  logic [STAT_W-1:0] rx_byte;

  assign accept = start && (st == P_IDLE);
  assign active = (st != P_IDLE);

  spi_byte_xfer #(.HALF_DIV(HALF_DIV)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(CMD_RD_STATUS),
    .rx_byte(rx_byte), .fin(fin), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso));

  poll_timer #(.TMR_W(TMR_W), .DEFAULT_TIMEOUT(DEFAULT_TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .budget(timeout_cycles),
    .run(active), .expired(expired));

  status_eval u_eval (
    .stat(rx_byte), .want_ready(want_rdy), .is_err(is_err), .is_met(is_met));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_IDLE; go <= 1'b0; want_rdy <= 1'b0; seen <= 1'b0;
      bus_req <= 1'b0; done <= 1'b0; status_q <= '0;
      res_ok <= 1'b0; res_timeout <= 1'b0; res_error <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        P_IDLE: if (accept) begin
          want_rdy <= mask_ready; bus_req <= 1'b1;
          res_ok <= 1'b0; res_timeout <= 1'b0; res_error <= 1'b0;
          st <= P_REQ;
        end
        P_REQ: if (bus_gnt) begin
          go <= 1'b1; st <= P_FIRST;
        end
        P_FIRST: if (fin) begin
          go <= 1'b1; st <= P_SECOND;
        end
        P_SECOND: if (fin) begin
          status_q <= rx_byte; seen <= 1'b1;
          if (is_err || is_met || expired) begin
            res_error   <= is_err;
            res_ok      <= !is_err && is_met;
            res_timeout <= !is_err && !is_met;
            done <= 1'b1; bus_req <= 1'b0; st <= P_IDLE;
          end else begin
            go <= 1'b1; st <= P_FIRST;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  assign operating = seen && !program_mode && (status_q == '0);

  // R6: no chip-select activity without an owned bus
  assert_cs_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> (bus_req && bus_gnt));
  // R6: bus handed back when the poll reports
  assert_req_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  // R7: exactly one verdict with each completion
  assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({res_ok, res_timeout, res_error}));
  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a start during a poll leaves it running
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !done) |=> active);
endmodule

// File: tb/test_spi_status_poller.sv
module test_spi_status_poller;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mask_ready = 1'b0, program_mode = 1'b0;
  logic [31:0] timeout_cycles = '0;
  logic bus_req, spi_sclk, spi_cs_n, spi_mosi, done, active, operating;
  logic bus_gnt = 1'b0, spi_miso = 1'b0;
  logic [7:0] status_q;
  logic res_ok, res_timeout, res_error;

  always #5 clk = ~clk;

  spi_status_poller i_spi_status_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_ready(mask_ready),
    .timeout_cycles(timeout_cycles), .program_mode(program_mode),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .done(done), .status_q(status_q), .res_ok(res_ok),
    .res_timeout(res_timeout), .res_error(res_error), .active(active),
    .operating(operating));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] scr [8];
  int xact = 0, mosi_bad = 0, gnt_viol = 0, gdly = 0;
  logic [7:0] cur, mcap;
  int bitn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // peripheral model: mode 0, reply MSB first
  always @(negedge spi_cs_n) begin
    xact++;
    if (!bus_gnt) gnt_viol++;
    if (xact % 2 == 1) cur = 8'($urandom);
    else cur = scr[(xact / 2 - 1) > 7 ? 7 : (xact / 2 - 1)];
    bitn = 0; mcap = 8'h00;
    spi_miso = cur[7];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) mcap = {mcap[6:0], spi_mosi};
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    bitn++;
    if (bitn < 8) spi_miso = cur[7 - bitn];
  end
  always @(posedge spi_cs_n) if (mcap != 8'h00) mosi_bad++;

  always @(posedge clk) begin
    if (!bus_req) bus_gnt <= 1'b0;
    else if (!bus_gnt) begin
      if (gdly == 0) bus_gnt <= 1'b1;
      else gdly <= gdly - 1;
    end
  end

  // 0 ok, 1 timeout, 2 error; sets number of samples
  function automatic int predict(input bit m, input int n, input bit short_tmo,
                                 output int samples, output logic [7:0] last);
    logic [7:0] mk = m ? 8'h02 : 8'h00;
    for (int i = 0; i < n; i++) begin
      samples = i + 1; last = scr[i];
      if ((scr[i] & 8'h0C) != 0) return 2;
      if ((scr[i] & (8'h01 | mk)) == mk) return 0;
      if (short_tmo) return 1;
    end
    return 1;
  endfunction

  task automatic run_case(input bit m, input logic [31:0] tmo, input int n,
                          input int gd, input bit poke, input string tag);
    int kind, smp, w;
    logic [7:0] last;
    kind = predict(m, n, (tmo != 0 && tmo < 8), smp, last);
    xact = 0; mosi_bad = 0; gnt_viol = 0; gdly = gd;
    @(negedge clk); start = 1'b1; mask_ready = m; timeout_cycles = tmo;
    @(negedge clk); start = 1'b0;
    chk(bus_req === 1'b1 && active === 1'b1, {tag, " R6 req"}, int'(bus_req), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 20000) begin @(negedge clk); w++; end
    chk(res_ok === (kind == 0), {tag, " R4 ok"}, int'(res_ok), int'(kind == 0));
    chk(res_timeout === (kind == 1), {tag, " R5 timeout"}, int'(res_timeout), int'(kind == 1));
    chk(res_error === (kind == 2), {tag, " R3 error"}, int'(res_error), int'(kind == 2));
    chk(status_q === last, {tag, " R7 status"}, int'(status_q), int'(last));
    chk(bus_req === 1'b0, {tag, " R6 release"}, int'(bus_req), 0);
    chk(xact == 2 * smp, {tag, " R2 xacts"}, xact, 2 * smp);
    chk(mosi_bad == 0, {tag, " R1 mosi"}, mosi_bad, 0);
    chk(gnt_viol == 0, {tag, " R6 grant"}, gnt_viol, 0);
    @(negedge clk);
    chk(done === 1'b0 && active === 1'b0, {tag, " R7 pulse"}, int'(done), 0);
    chk(res_ok === (kind == 0) && res_error === (kind == 2), {tag, " R7 hold"}, int'(res_ok), int'(kind == 0));
    if (poke) begin
      repeat (100) @(negedge clk);
      chk(done === 1'b0 && xact == 2 * smp, {tag, " R8 ignored"}, xact, 2 * smp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 spi idle", int'(spi_cs_n), 1);
    chk(bus_req === 1'b0 && done === 1'b0 && active === 1'b0, "R10 ctrl", int'(bus_req), 0);
    chk({res_ok, res_timeout, res_error} === 3'b000, "R10 flags", int'({res_ok, res_timeout, res_error}), 0);
    chk(operating === 1'b0, "R10 operating", int'(operating), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 mask none: idle status succeeds
    scr[0] = 8'h00; run_case(1'b0, 32'd100000, 1, 0, 1'b0, "mask none");
    chk(operating === 1'b1, "R9 operating", int'(operating), 1);
    program_mode = 1'b1; #1;
    chk(operating === 1'b0, "R9 program mode", int'(operating), 0);
    program_mode = 1'b0;
    // R4 mask ready: busy then ready
    scr[0] = 8'h01; scr[1] = 8'h03; scr[2] = 8'h02;
    run_case(1'b1, 32'd100000, 3, 2, 1'b0, "mask ready");
    chk(operating === 1'b0, "R9 nonzero", int'(operating), 0);
    // R3 error beats success; R2 garbage first reply ignored by design
    scr[0] = 8'h04; run_case(1'b0, 32'd100000, 1, 1, 1'b0, "viol");
    scr[0] = 8'h0A; run_case(1'b1, 32'd100000, 1, 0, 1'b0, "link err");
    // R5 short budget: timeout after first sample
    scr[0] = 8'h01; run_case(1'b0, 32'd3, 1, 0, 1'b0, "timeout busy");
    scr[0] = 8'h00; run_case(1'b1, 32'd3, 1, 0, 1'b0, "timeout notready");
    // R5 success wins over expired budget
    scr[0] = 8'h02; run_case(1'b1, 32'd1, 1, 0, 1'b0, "ok at expiry");
    // R5 zero budget selects default
    scr[0] = 8'h01; scr[1] = 8'h01; scr[2] = 8'hF0;
    run_case(1'b0, 32'd0, 3, 0, 1'b0, "default tmo");
    // R8 start while active
    scr[0] = 8'h01; scr[1] = 8'h01; scr[2] = 8'h01; scr[3] = 8'h00;
    run_case(1'b0, 32'd100000, 4, 0, 1'b1, "restart");
    // random mix
    for (int k = 0; k < 30; k++) begin
      int n = 1 + int'($urandom % 6);
      bit m = 1'($urandom);
      for (int i = 0; i < n - 1; i++) scr[i] = 8'h01 | (8'($urandom) & 8'hF2);
      if ($urandom % 2 == 0) scr[n-1] = (m ? 8'h02 : 8'h00) | (8'($urandom) & 8'hF2);
      else scr[n-1] = ($urandom % 2 == 0 ? 8'h04 : 8'h08) | 8'($urandom);
      run_case(m, 32'd100000, n, int'($urandom % 4), 1'b0, "random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule